// File: doc/BRIEF.md
# Serial-Data FSK Tone Generator

This block turns a byte of serial data into a frequency-shift-keyed square wave. An interval counter advances on a clock-enable pulse (`tick`). It counts from 0 up to the active compare value and then restarts, flipping the output wave each time it restarts. There are two compare values: one for data bit 0 and one for data bit 1. The current data bit, the MSB of a small internal shift register, picks which one sets the next half-period. The output therefore swings between two tones as the data changes.

The shift register gets its shift clock from a second divider, and that divider counts the wave's own toggle events. After `TOG_PER_BIT` toggles (by default 2, one full output cycle), the register moves on to the next bit. The byte enters through a valid/ready load port. `load_ready` is high only while the block is idle, so a producer holding `load_valid` is back-pressured until the current byte has been sent. Once the eighth bit is sent, the block returns to idle and pulses `done`.

Top module: `fsk_tone_gen`

## Requirements
- R1: After reset, `fsk_out`, `data_bit` and `done` are 0 and `load_ready` is 1.
- R2: A byte is taken on a clock edge where `load_valid` and `load_ready` are both high. `load_ready` stays low from that edge until the byte has been fully sent. A `load_valid` held during that time has no effect until `load_ready` returns.
- R3: Each half-period of `fsk_out` lasts (N+1) ticks. N is `cmp_zero` when the active data bit is 0 and `cmp_one` when it is 1. `fsk_out` toggles on the tick that ends each half-period, and the first half-period starts at the accepting edge.
- R4: Bits are sent MSB first (bit 7 first), and each bit lasts `TOG_PER_BIT` half-periods (default 2). `data_bit` shows the bit that is currently being sent.
- R5: A compare value of 0 is treated as 1, which gives a half-period of 2 ticks.
- R6: The compare value for a half-period is latched when that half-period starts. A change to `cmp_zero` or `cmp_one` in the middle of a half-period takes effect from the next half-period.
- R7: The counter and the toggle divider advance only on cycles where `tick` is high. A cycle without a tick (and without a load) leaves `fsk_out` and `data_bit` unchanged.
- R8: On the edge that ends the final half-period of bit 0, `done` pulses high for exactly one cycle. On that same edge `fsk_out` and `data_bit` return to 0 and `load_ready` returns to 1.
- R9: While idle, `fsk_out` and `data_bit` are held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable that advances the interval counter |
| cmp_zero | input | CNT_W | Half-period compare value used for data bit 0 |
| cmp_one | input | CNT_W | Half-period compare value used for data bit 1 |
| load_valid | input | 1 | A data byte is offered |
| load_ready | output | 1 | The block is idle and will take the offered byte |
| load_data | input | WORD_W | Byte to send, MSB first |
| fsk_out | output | 1 | FSK square-wave output |
| data_bit | output | 1 | Bit currently being sent (0 when idle) |
| done | output | 1 | One-cycle pulse when the last bit has been sent |

## Verification
The bench times every half-period in ticks and checks each one against the length expected from the data bit and the compare value. A design that took the wrong compare register, or counted 0..N-1, would be off by one tick or by a whole tone. A compare value of 0 is included; a design that did not clamp it would either stall or produce one-tick intervals. The bench also changes a compare value in the middle of an interval, which catches a design that applies the change at once instead of at the next restart. A second byte is offered while the first is still being sent, and the tick is gated irregularly. These catch a block that drops or overwrites a byte under back-pressure, or one that counts cycles rather than ticks. The end of a byte is checked in the exact cycle: `done`, an idle output and the return of `load_ready` must all appear on the final toggle edge.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  // Default widths shared by the generator and its sub-blocks.
  localparam int unsigned CNT_W_DEF  = 8;
  localparam int unsigned WORD_W_DEF = 8;
  localparam int unsigned TOG_DEF    = 2;
endpackage

// File: rtl/fsk_interval_timer.sv
module fsk_interval_timer #(
  parameter int unsigned CNT_W = fsk_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic             last,
  input  logic [CNT_W-1:0] start_lim,
  input  logic [CNT_W-1:0] next_lim,
  output logic             hit,
  output logic             wave
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_q;

  // Restart point: the count has reached the limit latched for this interval.
  assign hit = run && tick && (cnt >= lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      lim_q <= CNT_W'(1);
      wave  <= 1'b0;
    end else if (start) begin
      cnt   <= '0;
      lim_q <= start_lim;
      wave  <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (tick) begin
      if (hit) begin
        cnt   <= '0;
        lim_q <= next_lim;
        wave  <= last ? 1'b0 : ~wave;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fsk_bit_shifter.sv
module fsk_bit_shifter #(
  parameter int unsigned WORD_W      = fsk_pkg::WORD_W_DEF,
  parameter int unsigned TOG_PER_BIT = fsk_pkg::TOG_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              toggle,
  output logic              busy,
  output logic              cur_bit,
  output logic              next_bit,
  output logic              last,
  output logic              done
);
  localparam int unsigned TW = (TOG_PER_BIT > 1) ? $clog2(TOG_PER_BIT) : 1;
  localparam int unsigned BW = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  logic [WORD_W-1:0] sr;
  logic [TW-1:0]     tog_cnt;
  logic [BW-1:0]     bit_cnt;
  logic              bit_end;

  assign bit_end  = busy && toggle && (tog_cnt == TW'(TOG_PER_BIT - 1));
  assign last     = bit_end && (bit_cnt == BW'(WORD_W - 1));
  assign cur_bit  = busy & sr[WORD_W-1];
  assign next_bit = bit_end ? sr[WORD_W-2] : sr[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr      <= '0;
      tog_cnt <= '0;
      bit_cnt <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= last;
      if (start) begin
        sr      <= word;
        tog_cnt <= '0;
        bit_cnt <= '0;
        busy    <= 1'b1;
      end else if (busy && toggle) begin
        if (bit_end) begin
          tog_cnt <= '0;
          sr      <= {sr[WORD_W-2:0], 1'b0};
          bit_cnt <= bit_cnt + BW'(1);
          if (last) busy <= 1'b0;
        end else begin
          tog_cnt <= tog_cnt + TW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int unsigned CNT_W       = fsk_pkg::CNT_W_DEF,
  parameter int unsigned WORD_W      = fsk_pkg::WORD_W_DEF,
  parameter int unsigned TOG_PER_BIT = fsk_pkg::TOG_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cmp_zero,
  input  logic [CNT_W-1:0]  cmp_one,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [WORD_W-1:0] load_data,
  output logic              fsk_out,
  output logic              data_bit,
  output logic              done
);
  logic busy, start, hit, last, next_bit;
  logic [CNT_W-1:0] start_lim, next_lim;

  function automatic logic [CNT_W-1:0] pick_lim(input logic b,
                                                input logic [CNT_W-1:0] z,
                                                input logic [CNT_W-1:0] o);
    logic [CNT_W-1:0] v;
    v = b ? o : z;
    return (v == '0) ? CNT_W'(1) : v;
  endfunction

  assign load_ready = ~busy;
  assign start      = load_valid & ~busy;
  assign start_lim  = pick_lim(load_data[WORD_W-1], cmp_zero, cmp_one);
  assign next_lim   = pick_lim(next_bit, cmp_zero, cmp_one);

  fsk_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .run(busy), .tick(tick),
    .last(last), .start_lim(start_lim), .next_lim(next_lim),
    .hit(hit), .wave(fsk_out)
  );

  fsk_bit_shifter #(.WORD_W(WORD_W), .TOG_PER_BIT(TOG_PER_BIT)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .word(load_data), .toggle(hit),
    .busy(busy), .cur_bit(data_bit), .next_bit(next_bit), .last(last),
    .done(done)
  );
endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic load_valid,
  input logic load_ready,
  input logic fsk_out,
  input logic data_bit,
  input logic done
);
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |=> !load_ready);

  p_hold_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(load_valid && load_ready)) |=> ($stable(fsk_out) && $stable(data_bit)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (load_ready && !fsk_out && !data_bit));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_ready |-> (!fsk_out && !data_bit));
endmodule

bind fsk_tone_gen fsk_tone_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .load_valid(load_valid),
  .load_ready(load_ready), .fsk_out(fsk_out), .data_bit(data_bit), .done(done)
);

// File: tb/sim_fsk_tone_gen.sv
`timescale 1ns/1ps
module sim_fsk_tone_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic [7:0] cmp_zero = 8'd3, cmp_one = 8'd6;
  logic load_valid = 1'b0;
  logic [7:0] load_data = 8'd0;
  logic load_ready, fsk_out, data_bit, done;

  int checks = 0, failures = 0;
  int tick_mode = 0;
  bit inflight = 1'b0;

  typedef struct { logic b; int n; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  fsk_tone_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_zero(cmp_zero), .cmp_one(cmp_one),
    .load_valid(load_valid), .load_ready(load_ready), .load_data(load_data),
    .fsk_out(fsk_out), .data_bit(data_bit), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Tick generator: always on, or two ticks out of every three cycles.
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      tick = (tick_mode == 0) ? 1'b1 : ((cyc % 3) != 2);
    end
  end

  // Driver: offers a byte and pushes the expected half-periods once it is taken.
  task automatic send(input logic [7:0] w, input int zero_after, input string tag);
    int lo;
    @(posedge clk); #1;
    load_valid = 1'b1;
    load_data  = w;
    do @(negedge clk); while (!load_ready);
    @(posedge clk); #1;
    load_valid = 1'b0;
    lo = int'(cmp_zero);
    for (int i = 7; i >= 0; i--) begin
      for (int t = 0; t < 2; t++) begin
        int v;
        item_t it;
        v = w[i] ? int'(cmp_one) : lo;
        if (v == 0) v = 1;
        it.b = w[i]; it.n = v + 1; it.tag = tag;
        q.push_back(it);
        if (zero_after >= 0) lo = zero_after;
      end
    end
    if (zero_after >= 0) cmp_zero = 8'(zero_after);
  endtask

  task automatic wait_idle();
    while (inflight || q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(fsk_out == 1'b0, "R9 idle fsk", fsk_out, 0);
    check(data_bit == 1'b0, "R9 idle bit", data_bit, 0);
  endtask

  // Monitor: times each half-period in ticks and compares it with the queue.
  initial begin
    int run = 0;
    logic prev_fsk = 1'b0, prev_db = 1'b0;
    bit pend = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        bit acc;
        if (pend) begin
          check(fsk_out == prev_fsk, "R7 no-tick fsk", fsk_out, prev_fsk);
          check(data_bit == prev_db, "R7 no-tick bit", data_bit, prev_db);
        end
        if (fsk_out != prev_fsk) begin
          if (q.size() == 0) begin
            check(1'b0, "R3 unexpected toggle", 1, 0);
          end else begin
            item_t it;
            it = q.pop_front();
            check(run == it.n, {it.tag, " R3 half-period ticks"}, run, it.n);
            if (q.size() != 0) begin
              check(data_bit == q[0].b, "R4 data_bit", data_bit, q[0].b);
            end else begin
              check(done == 1'b1, "R8 done at end", done, 1);
              check(load_ready == 1'b1, "R8 ready at end", load_ready, 1);
              check(data_bit == 1'b0, "R8 bit cleared", data_bit, 0);
              inflight = 1'b0;
            end
          end
          run = 0;
        end else if (done) begin
          check(1'b0, "R8 stray done", 1, 0);
        end
        if (inflight && load_ready) check(1'b0, "R2 ready while busy", 1, 0);
        acc = load_valid && load_ready;
        if (acc) begin
          run = 0;
          inflight = 1'b1;
        end else begin
          run += int'(tick);
        end
        pend = !tick && !acc;
        prev_fsk = fsk_out;
        prev_db  = data_bit;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(fsk_out == 1'b0, "R1 fsk", fsk_out, 0);
    check(data_bit == 1'b0, "R1 bit", data_bit, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(load_ready == 1'b1, "R1 ready", load_ready, 1);

    // R3/R4 plus back-pressure (R2): second byte offered while the first runs.
    cmp_zero = 8'd3; cmp_one = 8'd6;
    send(8'hA5, -1, "R4");
    @(negedge clk);
    check(load_ready == 1'b0, "R2 busy after accept", load_ready, 0);
    send(8'h3C, -1, "R2");
    wait_idle();

    // R5: a zero compare value is clamped to 1.
    cmp_zero = 8'd0; cmp_one = 8'd2;
    send(8'hF0, -1, "R5");
    wait_idle();

    // R6: compare value changed mid-interval applies from the next interval.
    cmp_zero = 8'd3; cmp_one = 8'd5;
    send(8'h00, 9, "R6");
    wait_idle();

    // R7: gated tick.
    cmp_zero = 8'd2; cmp_one = 8'd4;
    tick_mode = 1;
    send(8'h6B, -1, "R7");
    wait_idle();
    tick_mode = 0;

    check(q.size() == 0, "R3 all intervals seen", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule